// File: doc/BRIEF.md
# Command-Stream JTAG Scan Engine

This block is a JTAG master that runs from a packed stream of command bytes instead of pin-level bit banging. Software pushes instruction, length and payload bytes into a byte-wide write FIFO through three write ports. The ports take one, two or four bytes per access, and multi-byte accesses are split in little-endian order. A sequencer pops the stream and decodes two kinds of instruction. A TMS-walk instruction steps the TAP state machine along a short encoded path. A shift instruction moves up to 128 payload bits out on TDI and can capture TDO.

Captured TDO bits are packed into 32-bit words in a small read FIFO, and software pops them through the word port. A status register reports whether the sequencer is busy and how full the write FIFO is. Software treats the engine as idle only when the whole status word reads zero. A port-select register picks one scan port at a time, and its value goes out to the pad-side routing. TCK runs at half the system clock.

Top module: `scan_cmd_engine`

## Requirements
- R1: After reset, TCK is 0, TMS is 1, TDI is 0, the port-select register reads 0 and the status register reads 0.
- R2: A write to offset 2, 3 or 4 pushes 1, 2 or 4 bytes, taken from the low end of the write data first (little-endian). If the write FIFO lacks room for all of them, the whole access is dropped.
- R3: A read at offset 0 returns the status: bit 31 is 1 while the sequencer is not idle, bits 30:28 give the write-FIFO byte count saturated at 7, and all other bits are 0.
- R4: An instruction byte with bit 7 = 0 is a TMS walk. Its bits 5:0 are sent on TMS one per TCK pulse, least significant first, stopping before the highest set bit, which only marks the end. An argument of 0 or 1 gives no TCK pulse.
- R5: A TMS walk with bit 6 set is followed by a length byte and payload that is shifted on TDI with TMS at 0 and without capture.
- R6: An instruction byte with bit 7 = 1 is a shift. With bit 4 set, a length byte follows, whose bits 6:0 plus one give the bit count (1 to 128); bit 7 of the length byte is ignored. Payload bits go out on TDI least significant first, bytes in arrival order, with TMS at 0. Unused bits of the last byte are discarded. With bit 4 clear, the shift instruction causes no TCK pulse.
- R7: Each bit takes two system clocks. TMS and TDI change only when TCK falls and stay steady while TCK is high, and TCK is never high for two clocks in a row.
- R8: In a shift with instruction bit 2 set, the TDO value at each TCK rise is captured. Capture bit j goes to bit (j mod 32) of a word, and a word is pushed to the read FIFO after every 32 bits and at the end of the command. The last word is right-aligned with zeros above. With bit 2 clear, nothing is captured.
- R9: A read at offset 4 returns and removes the oldest captured word. Reading an empty read FIFO returns 0.
- R10: Offset 1 holds the port-select value. A write with more than one bit set is ignored, and reads return the held value, which is also driven on `port_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read FIFO at offset 4) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| port_en | output | PORTS (8) | Selected scan port, at most one bit set |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the TAP |
| tdo | input | 1 | JTAG data from the TAP |

## Verification
The assertions check the pin-level rules on every cycle. TMS and TDI must hold while TCK is high, and each TCK high phase lasts one clock. A TCK rise may only come from a busy sequencer, and TMS must be low during payload shifting. The FIFO counts must stay within their depths, and the port-select value must be one-hot or zero. Only the bench scenarios show that the bytes are decoded correctly: the end-marker rule of the TMS walk, the length-minus-one count with its ignored top bit, and the little-endian byte order. The same holds for the word packing of captured TDO, the dropping of an access that does not fit, and the exact status value after a given write.

// File: rtl/scan_eng_pkg.sv
package scan_eng_pkg;

  localparam logic [2:0] OFS_STATUS = 3'd0;
  localparam logic [2:0] OFS_PORTS  = 3'd1;
  localparam logic [2:0] OFS_PUSH1  = 3'd2;
  localparam logic [2:0] OFS_PUSH2  = 3'd3;
  localparam logic [2:0] OFS_WORD   = 3'd4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WALK  = 2'd1,
    SQ_LEN   = 2'd2,
    SQ_SHIFT = 2'd3
  } seq_state_t;

  // Number of TMS bits a walk argument emits: index of its highest set bit.
  function automatic logic [2:0] walk_len(input logic [5:0] arg);
    logic [2:0] n;
    n = 3'd0;
    for (int i = 1; i < 6; i++) begin
      if (arg[i]) n = 3'(i);
    end
    return n;
  endfunction

  // Payload bit count from a length byte; its top bit is ignored.
  function automatic logic [7:0] len_to_bits(input logic [7:0] lb);
    return {1'b0, lb[6:0]} + 8'd1;
  endfunction

  // Occupancy field of the status word, saturated to three bits.
  function automatic logic [2:0] occ_field(input int unsigned cnt);
    return (cnt > 7) ? 3'd7 : 3'(cnt);
  endfunction

endpackage

// File: rtl/scan_wfifo.sv
module scan_wfifo #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  push_n,
  input  logic [31:0] push_data,
  input  logic        pop,
  output logic [7:0]  head,
  output logic        empty,
  output logic [AW:0] count
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   room;
  logic          accept;

  assign room   = (AW+1)'(DEPTH) - count;
  assign accept = (push_n != 3'd0) && (room >= (AW+1)'(push_n));
  assign empty  = (count == '0);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (accept && (i < int'(push_n)))
        mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + AW'(push_n);
      if (pop)    rd_ptr <= rd_ptr + 1'b1;
      count <= count + (accept ? (AW+1)'(push_n) : '0) - (pop ? (AW+1)'(1) : '0);
    end
  end

  assert_wfifo_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  assert_wfifo_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/scan_rfifo.sv
module scan_rfifo #(
  parameter int AW = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] push_word,
  input  logic        pop,
  output logic [31:0] head,
  output logic        empty
);
  localparam int DEPTH = 1 << AW;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && (count != (AW+1)'(DEPTH));
  assign do_pop  = pop && !empty;
  assign head    = empty ? 32'd0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (do_push ? (AW+1)'(1) : '0) - (do_pop ? (AW+1)'(1) : '0);
    end
  end

  assert_rfifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wf_empty,
  input  logic [7:0]  wf_head,
  output logic        wf_pop,
  input  logic        tdo_i,
  output logic        tck_o,
  output logic        tms_o,
  output logic        tdi_o,
  output logic        busy_o,
  output logic        cap_push_o,
  output logic [31:0] cap_word_o
);
  seq_state_t  state;
  logic        ph;          // 0: set up data with TCK low, 1: raise TCK
  logic [5:0]  walk_sh;
  logic [2:0]  walk_cnt;
  logic        pl_pend;
  logic        cap_en;
  logic [7:0]  bits_left;
  logic [7:0]  byte_sh;
  logic [3:0]  byte_left;
  logic [31:0] cap_word;
  logic [4:0]  cap_idx;

  // named internal events
  logic have_byte, need_byte, last_bit, rise_evt;
  logic [31:0] cap_next;

  assign have_byte  = !wf_empty;
  assign need_byte  = (byte_left == 4'd0);
  assign last_bit   = (bits_left == 8'd1);
  assign rise_evt   = ph && ((state == SQ_WALK) || (state == SQ_SHIFT));
  assign busy_o     = (state != SQ_IDLE);
  assign cap_next   = cap_word | (32'(tdo_i) << cap_idx);
  assign cap_push_o = (state == SQ_SHIFT) && ph && cap_en &&
                      ((cap_idx == 5'd31) || last_bit);
  assign cap_word_o = cap_next;

  always_comb begin
    unique case (state)
      SQ_IDLE:  wf_pop = have_byte;
      SQ_LEN:   wf_pop = have_byte;
      SQ_SHIFT: wf_pop = !ph && need_byte && have_byte;
      default:  wf_pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      ph        <= 1'b0;
      tck_o     <= 1'b0;
      tms_o     <= 1'b1;
      tdi_o     <= 1'b0;
      walk_sh   <= '0;
      walk_cnt  <= '0;
      pl_pend   <= 1'b0;
      cap_en    <= 1'b0;
      bits_left <= '0;
      byte_sh   <= '0;
      byte_left <= '0;
      cap_word  <= '0;
      cap_idx   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          tck_o <= 1'b0;
          ph    <= 1'b0;
          if (have_byte) begin
            if (!wf_head[7]) begin
              walk_sh  <= wf_head[5:0];
              walk_cnt <= walk_len(wf_head[5:0]);
              pl_pend  <= wf_head[6];
              cap_en   <= 1'b0;
              if (walk_len(wf_head[5:0]) != 3'd0) state <= SQ_WALK;
              else if (wf_head[6])                state <= SQ_LEN;
            end else begin
              pl_pend <= 1'b0;
              cap_en  <= wf_head[2];
              if (wf_head[4]) state <= SQ_LEN;
            end
          end
        end
        SQ_WALK: begin
          if (!ph) begin
            tck_o <= 1'b0;
            tms_o <= walk_sh[0];
            ph    <= 1'b1;
          end else begin
            tck_o    <= 1'b1;
            walk_sh  <= walk_sh >> 1;
            walk_cnt <= walk_cnt - 3'd1;
            ph       <= 1'b0;
            if (walk_cnt == 3'd1) state <= pl_pend ? SQ_LEN : SQ_IDLE;
          end
        end
        SQ_LEN: begin
          tck_o <= 1'b0;
          if (have_byte) begin
            bits_left <= len_to_bits(wf_head);
            byte_left <= 4'd0;
            cap_word  <= '0;
            cap_idx   <= '0;
            ph        <= 1'b0;
            state     <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (!ph) begin
            tck_o <= 1'b0;
            tms_o <= 1'b0;
            if (!need_byte) begin
              tdi_o     <= byte_sh[0];
              byte_sh   <= byte_sh >> 1;
              byte_left <= byte_left - 4'd1;
              ph        <= 1'b1;
            end else if (have_byte) begin
              tdi_o     <= wf_head[0];
              byte_sh   <= {1'b0, wf_head[7:1]};
              byte_left <= 4'd7;
              ph        <= 1'b1;
            end
          end else begin
            tck_o     <= 1'b1;
            ph        <= 1'b0;
            bits_left <= bits_left - 8'd1;
            if (cap_en) begin
              cap_word <= cap_push_o ? 32'd0 : cap_next;
              cap_idx  <= cap_idx + 5'd1;
            end
            if (last_bit) state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_pins_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tck_o |-> ($stable(tms_o) && $stable(tdi_o)));

  assert_tck_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tck_o |=> !tck_o);

  assert_rise_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck_o) |-> $past(busy_o));

  assert_shift_tms_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SQ_SHIFT) && tck_o) |-> !tms_o);

  assert_rise_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> tck_o);

endmodule

// File: rtl/scan_cmd_engine.sv
module scan_cmd_engine
  import scan_eng_pkg::*;
#(
  parameter int WF_AW = 4,
  parameter int RF_AW = 2,
  parameter int PORTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [PORTS-1:0] port_en,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo
);
  logic [2:0]       push_n;
  logic             wf_pop, wf_empty;
  logic [7:0]       wf_head;
  logic [WF_AW:0]   wf_count;
  logic             busy, cap_push;
  logic [31:0]      cap_word, rf_head;
  logic             rf_empty, rf_pop;
  logic [PORTS-1:0] en_req;
  logic             en_ok;

  always_comb begin
    push_n = 3'd0;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_PUSH1: push_n = 3'd1;
        OFS_PUSH2: push_n = 3'd2;
        OFS_WORD:  push_n = 3'd4;
        default:   push_n = 3'd0;
      endcase
    end
  end

  assign rf_pop = reg_rd && (reg_addr == OFS_WORD);
  assign en_req = reg_wdata[PORTS-1:0];
  assign en_ok  = ((en_req & (en_req - 1'b1)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_en <= '0;
    else if (reg_wr && (reg_addr == OFS_PORTS) && en_ok) port_en <= en_req;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STATUS: reg_rdata = {busy, occ_field(32'(wf_count)), 28'd0};
      OFS_PORTS:  reg_rdata = 32'(port_en);
      OFS_WORD:   reg_rdata = rf_head;
      default:    reg_rdata = 32'd0;
    endcase
  end

  scan_wfifo #(.AW(WF_AW)) u_wfifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (push_n),
    .push_data (reg_wdata),
    .pop       (wf_pop),
    .head      (wf_head),
    .empty     (wf_empty),
    .count     (wf_count)
  );

  scan_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wf_empty   (wf_empty),
    .wf_head    (wf_head),
    .wf_pop     (wf_pop),
    .tdo_i      (tdo),
    .tck_o      (tck),
    .tms_o      (tms),
    .tdi_o      (tdi),
    .busy_o     (busy),
    .cap_push_o (cap_push),
    .cap_word_o (cap_word)
  );

  scan_rfifo #(.AW(RF_AW)) u_rfifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (cap_push),
    .push_word (cap_word),
    .pop       (rf_pop),
    .head      (rf_head),
    .empty     (rf_empty)
  );

  assert_port_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_en));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_empty && (reg_addr == OFS_WORD)) |-> (reg_rdata == 32'd0));

endmodule

// File: tb/sim_scan_cmd_engine.sv
module sim_scan_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [7:0]  port_en;
  logic        tck, tms, tdi;
  logic        tdo;

  always #5 clk = ~clk;

  scan_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_en(port_en), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // TAP stand-in: TDO follows a pattern indexed by completed TCK pulses.
  function automatic logic pat(input int k);
    return logic'((k ^ (k >> 2) ^ (k >> 5)) & 1);
  endfunction
  int ridx = 0;
  always @(negedge tck) ridx = ridx + 1;
  assign tdo = pat(ridx);

  // Scoreboard: {check_tdi, tms, tdi} and requirement tag per expected pulse
  logic [2:0] exp_q [$];
  int         tag_q [$];
  int         rises = 0;
  logic tck_p = 1'b0, tms_p = 1'b1, tdi_p = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tck && tck_p) begin
        nchk++; nerr++;
        $display("FAIL R7 tck high twice act=1 exp=0");
      end
      if (tck && ((tms !== tms_p) || (tdi !== tdi_p))) begin
        nchk++; nerr++;
        $display("FAIL R7 pins moved with tck high act=%b%b exp=%b%b", tms, tdi, tms_p, tdi_p);
      end
      if (tck && !tck_p) begin
        rises++;
        nchk++;
        if (exp_q.size() == 0) begin
          nerr++;
          $display("FAIL R4 unexpected tck pulse act=%b%b exp=none", tms, tdi);
        end else begin
          logic [2:0] e;
          int t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ((tms !== e[1]) || (e[2] && (tdi !== e[0]))) begin
            nerr++;
            $display("FAIL R%0d pulse act tms=%b tdi=%b exp tms=%b tdi=%b", t, tms, tdi, e[1], e[0]);
          end
        end
      end
    end
    tck_p = tck; tms_p = tms; tdi_p = tdi;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000; n++) begin
      reg_addr = 3'd0;
      #1;
      if (reg_rdata == 32'd0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic exp_walk(input logic [5:0] arg, input int tag);
    int top;
    top = 0;
    for (int i = 5; i >= 1; i--) if (arg[i]) begin top = i; break; end
    for (int i = 0; i < top; i++) begin exp_q.push_back({1'b0, arg[i], 1'b0}); tag_q.push_back(tag); end
  endtask

  task automatic exp_bits(input logic [127:0] v, input int n, input int tag);
    for (int i = 0; i < n; i++) begin exp_q.push_back({1'b1, 1'b0, v[i]}); tag_q.push_back(tag); end
  endtask

  // Read back captured words and compare with the pattern from pulse s on.
  task automatic check_capture(input int s, input int n);
    logic [31:0] got, want;
    for (int k = 0; k < (n + 31) / 32; k++) begin
      want = 32'd0;
      for (int j = k * 32; j < n && j < (k + 1) * 32; j++) want[j - k * 32] = pat(s + j);
      rd(3'd4, got);
      chk("R8 captured word", got, want);
    end
    rd(3'd4, got);
    chk("R9 empty read", got, 32'd0);
  endtask

  task automatic shift_cmd(input logic cap, input int n, input logic [127:0] v);
    int full, rem;
    exp_bits(v, n, 6);
    wr(3'd3, {16'd0, 8'(n - 1), (cap ? 8'h94 : 8'h90)});
    full = n / 32; rem = n % 32;
    for (int i = 0; i < full; i++) wr(3'd4, v[32*i +: 32]);
    for (int j = 0; j < rem; j += 8) wr(3'd2, {24'd0, v[32*full + j +: 8]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int s, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tck", 32'(tck), 32'd0);
    chk("R1 tms", 32'(tms), 32'd1);
    chk("R1 tdi", 32'(tdi), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R1 status", d, 32'd0);
    rd(3'd1, d); chk("R1 port select", d, 32'd0);

    // R10 port select
    wr(3'd1, 32'h80); rd(3'd1, d); chk("R10 select bit7", d, 32'h80);
    chk("R10 port_en pins", 32'(port_en), 32'h80);
    wr(3'd1, 32'h81); rd(3'd1, d); chk("R10 two bits ignored", d, 32'h80);
    wr(3'd1, 32'h04); rd(3'd1, d); chk("R10 select bit2", d, 32'h04);
    wr(3'd1, 32'h00); chk("R10 cleared", 32'(port_en), 32'h0);

    // R3 status timing and R4 walk of five ones
    exp_walk(6'h3F, 4);
    wr(3'd2, 32'h3F);
    reg_addr = 3'd0; #1 chk("R3 status one byte queued", reg_rdata, 32'h1000_0000);
    @(negedge clk); #1 chk("R3 status busy", reg_rdata, 32'h8000_0000);
    wait_idle();
    chk("R4 five ones consumed", 32'(exp_q.size()), 32'd0);

    // R4 walk 0,1,0,0 then arguments that emit nothing
    exp_walk(6'h12, 4);
    wr(3'd2, 32'h12);
    wait_idle();
    r0 = rises;
    wr(3'd2, 32'h01); wr(3'd2, 32'h00);
    wait_idle();
    chk("R4 no pulse for 0 and 1", 32'(rises), 32'(r0));

    // R6 shift without payload flag does nothing
    wr(3'd2, 32'h80); wr(3'd2, 32'h84);
    wait_idle();
    chk("R6 no payload flag", 32'(rises), 32'(r0));

    // R6 eight bits, no capture
    shift_cmd(1'b0, 8, 128'hA5);
    wait_idle();
    rd(3'd4, d); chk("R8 nothing captured", d, 32'd0);

    // R8 32-bit capture with little-endian word payload (R2)
    s = ridx;
    shift_cmd(1'b1, 32, 128'h1234_5678);
    wait_idle();
    check_capture(s, 32);

    // R8 partial word; unused payload bits discarded
    s = ridx;
    shift_cmd(1'b1, 5, 128'hFF);
    wait_idle();
    check_capture(s, 5);
    exp_walk(6'h12, 4);
    wr(3'd2, 32'h12);
    wait_idle();
    chk("R6 leftover discarded", 32'(exp_q.size()), 32'd0);

    // R6 128 bits, length byte with top bit set
    s = ridx;
    exp_bits(128'hDEAD_BEEF_0F1E_2D3C_8899_AABB_C3C3_5A5A, 128, 6);
    wr(3'd3, 32'h0000_FF94);
    wr(3'd4, 32'hC3C3_5A5A); wr(3'd4, 32'h8899_AABB);
    wr(3'd4, 32'h0F1E_2D3C); wr(3'd4, 32'hDEAD_BEEF);
    wait_idle();
    chk("R6 128 bits sent", 32'(ridx - s), 32'd128);
    check_capture(s, 128);

    // R5 walk with payload: one TMS 0, then 4 bits of 0xA5 with TMS 0
    exp_walk(6'h02, 5);
    exp_bits(128'h5, 4, 5);
    wr(3'd3, 32'h0000_0342);
    wr(3'd2, 32'hA5);
    wait_idle();
    chk("R5 payload shifted", 32'(exp_q.size()), 32'd0);
    rd(3'd4, d); chk("R5 no capture", d, 32'd0);

    // R2 overflow: fifth word does not fit and is dropped whole
    s = ridx;
    exp_bits(128'h4444_4444_3333_3333_2222_2222_1111_1111, 128, 2);
    wr(3'd3, 32'h0000_7F90);
    wr(3'd4, 32'h1111_1111); wr(3'd4, 32'h2222_2222);
    wr(3'd4, 32'h3333_3333); wr(3'd4, 32'h4444_4444);
    wr(3'd4, 32'h3F3F_3F3F);
    reg_addr = 3'd0; #1 chk("R3 occupancy saturated", reg_rdata, 32'hF000_0000);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R2 dropped word left no pulses", 32'(ridx - s), 32'd128);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    rd(3'd0, d); chk("R3 idle status", d, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule